// File: doc/BRIEF.md
# Pipelined Burst Read Slave Controller

This block is the read-side sequencer of a bus slave. A master asks for data with an address-valid request that names a transfer kind (one word, a cache line, or a fixed-length burst) and a beat count. The controller acknowledges the address, forwards it towards the far side, and then hands data back one beat at a time. The data comes from a read FIFO that another clock domain fills. The controller pops that FIFO, flags beats that carry an error marker, and signals completion. A transfer aimed at the slave's own status registers is served without touching the FIFO, because that data is always available.

Line and burst reads insert one wait cycle after the address acknowledge, so that the first data acknowledge never arrives earlier than two cycles after it. The master may promote a second request while a transfer is running. The controller then acknowledges that address at once, holds it in a one-entry pending slot, and starts it right after the final beat of the current transfer. It enters the data phase directly, with no wait cycle. The second-to-last beat of a line or burst is only acknowledged when the FIFO reports at least two queued entries. This guarantees that the final beat can be acknowledged and popped on the very next cycle.

Top module: `burst_read_ctrl`

## Requirements
- R1: Synchronous reset `rst` returns the controller to idle and discards any pending promoted request. While idle with no request, every output is low.
- R2: In idle, `req_valid` gives `addr_ack` in the same cycle and starts a transfer. `push_addr` accompanies it only when `req_status` is 0 (the far side is the target). The `req_kind` encoding is 0 = single, 1 = line, 2 = burst, and 3 is treated as single.
- R3: A line or burst started from idle spends exactly one wait cycle with no data acknowledge, so the first `rd_ack` comes at least two cycles after `addr_ack`.
- R4: A single read asserts `rd_comp` without `rd_ack` in the first cycle the data is ready. It asserts `rd_ack` alone in the following cycle, then returns to idle. Data is ready when `fifo_empty` is 0, or always for a status target.
- R5: In the data phase of a line or burst with N beats (N from `req_beats`), each non-final beat before the second-to-last is acknowledged when the data is ready. The second-to-last beat is acknowledged only while `fifo_almost_empty` is 0 or the target is the status registers. The final beat is acknowledged in the very next cycle together with `rd_comp`. When N is 0 or 1, the controller moves to that final cycle once the data is ready.
- R6: `fifo_pop` is high exactly when `rd_ack` is high on a transfer to the far side. It is never high on a status transfer or outside an acknowledge.
- R7: `rd_err` is high with `rd_ack` when `fifo_err` is high on a far-side transfer. It is never high on a status transfer.
- R8: While busy outside the three acknowledge-cycle states, with the pending slot free, `promote` gives `addr_ack` in the same cycle, with `push_addr` for a far-side target. The request is started in the cycle after the current transfer's final acknowledge, directly in its data state with no wait cycle.
- R9: `promote` is ignored (no `addr_ack`, nothing remembered) in idle, in an acknowledge-cycle state, or while the pending slot is full.
- R10: `src_status` is high throughout a transfer whose target is the status registers and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Primary read request valid |
| req_kind | input | 2 | Transfer kind: 0 single, 1 line, 2 burst, 3 single |
| req_beats | input | BEAT_W | Beat count for line and burst |
| req_status | input | 1 | Request targets the internal status registers |
| promote | input | 1 | Secondary request promoted to primary (uses the req_* fields) |
| fifo_empty | input | 1 | Read FIFO holds no datum |
| fifo_almost_empty | input | 1 | Low when the read FIFO holds at least two data |
| fifo_err | input | 1 | Error marker stored with the FIFO head datum |
| addr_ack | output | 1 | Address acknowledge |
| push_addr | output | 1 | Push accepted address towards the far side |
| rd_ack | output | 1 | Read data acknowledge, one per beat |
| rd_comp | output | 1 | Read transfer complete |
| rd_err | output | 1 | Read error for the acknowledged beat |
| fifo_pop | output | 1 | Pop the read FIFO head |
| src_status | output | 1 | Current data comes from the status registers |

## Verification
The assertions assume that the FIFO flags are consistent: `fifo_almost_empty` low implies `fifo_empty` low, and a flag does not claim data that then vanishes without a pop. They also assume that `req_kind`, `req_beats` and `req_status` are valid whenever `req_valid` or `promote` is high. The stimulus table only presents flag combinations that a real FIFO can produce, and holds the request fields steady on every strobe cycle. The stall cases are made by withholding data through these flags, never by contradicting them.

// File: rtl/rdctl_pkg.sv
package rdctl_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SGL,
    S_SGL_ACK,
    S_LN_WAIT,
    S_LN,
    S_LN_ACK,
    S_BR_WAIT,
    S_BR,
    S_BR_ACK
  } rd_state_e;

  typedef enum logic [1:0] {
    K_SINGLE = 2'd0,
    K_LINE   = 2'd1,
    K_BURST  = 2'd2,
    K_RSVD   = 2'd3
  } xfer_kind_e;

  typedef struct packed {
    xfer_kind_e kind;
    logic       to_status;
  } req_attr_t;

  // First state of a transfer; a chained (promoted) one skips the wait cycle.
  function automatic rd_state_e entry_state(input xfer_kind_e kind, input logic chained);
    rd_state_e s;
    case (kind)
      K_LINE:  s = chained ? S_LN : S_LN_WAIT;
      K_BURST: s = chained ? S_BR : S_BR_WAIT;
      default: s = S_SGL;
    endcase
    return s;
  endfunction

  function automatic logic in_ack_state(input rd_state_e s);
    return (s == S_SGL_ACK) || (s == S_LN_ACK) || (s == S_BR_ACK);
  endfunction

  function automatic rd_state_e ack_of(input rd_state_e s);
    return (s == S_LN) ? S_LN_ACK : S_BR_ACK;
  endfunction

  // One datum available: status data is always present.
  function automatic logic head_ready(input logic to_status, input logic empty);
    return to_status | ~empty;
  endfunction

  // Two data available.
  function automatic logic pair_ready(input logic to_status, input logic almost_empty);
    return to_status | ~almost_empty;
  endfunction

endpackage

// File: rtl/rdctl_pend_slot.sv
module rdctl_pend_slot
  import rdctl_pkg::*;
#(
  parameter int BEAT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_i,
  input  logic              clr_i,
  input  req_attr_t         attr_i,
  input  logic [BEAT_W-1:0] beats_i,
  output logic              valid_o,
  output req_attr_t         attr_o,
  output logic [BEAT_W-1:0] beats_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      attr_o  <= '0;
      beats_o <= '0;
    end else if (set_i) begin
      valid_o <= 1'b1;
      attr_o  <= attr_i;
      beats_o <= beats_i;
    end else if (clr_i) begin
      valid_o <= 1'b0;
    end
  end

endmodule

// File: rtl/rdctl_beat_cnt.sv
module rdctl_beat_cnt #(
  parameter int BEAT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [BEAT_W-1:0] load_val_i,
  input  logic              dec_i,
  output logic [BEAT_W-1:0] cnt_o
);

  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)                         cnt_o <= '0;
    else if (load_i)                 cnt_o <= load_val_i;
    else if (dec_i && cnt_o != '0)   cnt_o <= cnt_o - ONE;
  end

endmodule

// File: rtl/rdctl_fsm.sv
module rdctl_fsm
  import rdctl_pkg::*;
#(
  parameter int BEAT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  req_attr_t         req_attr_i,
  input  logic              promote_i,
  input  logic              pend_valid_i,
  input  req_attr_t         pend_attr_i,
  input  logic              fifo_empty_i,
  input  logic              fifo_aempty_i,
  input  logic              fifo_err_i,
  input  logic [BEAT_W-1:0] cnt_i,
  output logic              addr_ack_o,
  output logic              push_addr_o,
  output logic              rd_ack_o,
  output logic              rd_comp_o,
  output logic              rd_err_o,
  output logic              pop_o,
  output logic              src_status_o,
  output logic              cnt_load_o,
  output logic              load_from_pend_o,
  output logic              cnt_dec_o,
  output logic              pend_set_o,
  output logic              pend_clr_o,
  output logic              take_idle_o,
  output logic              take_promote_o,
  output logic              pen_fire_o,
  output logic              sgl_comp_o
);

  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);
  localparam logic [BEAT_W-1:0] TWO = BEAT_W'(2);

  rd_state_e state_q, state_d;
  logic      cur_status_q, cur_status_d;
  logic      busy, head, pair, beat_ack, final_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      cur_status_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      cur_status_q <= cur_status_d;
    end
  end

  assign busy = (state_q != S_IDLE);
  assign head = head_ready(cur_status_q, fifo_empty_i);
  assign pair = pair_ready(cur_status_q, fifo_aempty_i);

  assign take_promote_o = promote_i & busy & ~in_ack_state(state_q) & ~pend_valid_i;

  always_comb begin
    state_d          = state_q;
    cur_status_d     = cur_status_q;
    take_idle_o      = 1'b0;
    sgl_comp_o       = 1'b0;
    pen_fire_o       = 1'b0;
    beat_ack         = 1'b0;
    final_ack        = 1'b0;
    cnt_load_o       = 1'b0;
    load_from_pend_o = 1'b0;
    pend_clr_o       = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (req_valid_i) begin
          take_idle_o  = 1'b1;
          cnt_load_o   = 1'b1;
          cur_status_d = req_attr_i.to_status;
          state_d      = entry_state(req_attr_i.kind, 1'b0);
        end
      end
      S_SGL: begin
        if (head) begin
          sgl_comp_o = 1'b1;
          state_d    = S_SGL_ACK;
        end
      end
      S_LN_WAIT: state_d = S_LN;
      S_BR_WAIT: state_d = S_BR;
      S_LN, S_BR: begin
        if (cnt_i <= ONE) begin
          if (head) state_d = ack_of(state_q);
        end else if (cnt_i == TWO) begin
          if (pair) begin
            beat_ack   = 1'b1;
            pen_fire_o = 1'b1;
            state_d    = ack_of(state_q);
          end
        end else if (head) begin
          beat_ack = 1'b1;
        end
      end
      S_SGL_ACK, S_LN_ACK, S_BR_ACK: begin
        final_ack = 1'b1;
        if (pend_valid_i) begin
          pend_clr_o       = 1'b1;
          cnt_load_o       = 1'b1;
          load_from_pend_o = 1'b1;
          cur_status_d     = pend_attr_i.to_status;
          state_d          = entry_state(pend_attr_i.kind, 1'b1);
        end else begin
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign rd_ack_o     = beat_ack | final_ack;
  assign rd_comp_o    = sgl_comp_o | (final_ack & (state_q != S_SGL_ACK));
  assign pop_o        = rd_ack_o & ~cur_status_q;
  assign rd_err_o     = rd_ack_o & ~cur_status_q & fifo_err_i;
  assign addr_ack_o   = take_idle_o | take_promote_o;
  assign push_addr_o  = (take_idle_o | take_promote_o) & ~req_attr_i.to_status;
  assign pend_set_o   = take_promote_o;
  assign cnt_dec_o    = beat_ack;
  assign src_status_o = busy & cur_status_q;

endmodule

// File: rtl/burst_read_ctrl.sv
module burst_read_ctrl
  import rdctl_pkg::*;
#(
  parameter int BEAT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [BEAT_W-1:0] req_beats,
  input  logic              req_status,
  input  logic              promote,
  input  logic              fifo_empty,
  input  logic              fifo_almost_empty,
  input  logic              fifo_err,
  output logic              addr_ack,
  output logic              push_addr,
  output logic              rd_ack,
  output logic              rd_comp,
  output logic              rd_err,
  output logic              fifo_pop,
  output logic              src_status
);

  req_attr_t         req_attr, pend_attr;
  logic              pend_valid, pend_set, pend_clr;
  logic [BEAT_W-1:0] pend_beats, cnt, cnt_load_val;
  logic              cnt_load, load_from_pend, cnt_dec;
  logic              take_idle, take_promote, pen_fire, sgl_comp;

  assign req_attr.kind      = xfer_kind_e'(req_kind);
  assign req_attr.to_status = req_status;
  assign cnt_load_val       = load_from_pend ? pend_beats : req_beats;

  rdctl_pend_slot #(.BEAT_W(BEAT_W)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .set_i   (pend_set),
    .clr_i   (pend_clr),
    .attr_i  (req_attr),
    .beats_i (req_beats),
    .valid_o (pend_valid),
    .attr_o  (pend_attr),
    .beats_o (pend_beats)
  );

  rdctl_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (cnt_load),
    .load_val_i (cnt_load_val),
    .dec_i      (cnt_dec),
    .cnt_o      (cnt)
  );

  rdctl_fsm #(.BEAT_W(BEAT_W)) u_fsm (
    .clk              (clk),
    .rst              (rst),
    .req_valid_i      (req_valid),
    .req_attr_i       (req_attr),
    .promote_i        (promote),
    .pend_valid_i     (pend_valid),
    .pend_attr_i      (pend_attr),
    .fifo_empty_i     (fifo_empty),
    .fifo_aempty_i    (fifo_almost_empty),
    .fifo_err_i       (fifo_err),
    .cnt_i            (cnt),
    .addr_ack_o       (addr_ack),
    .push_addr_o      (push_addr),
    .rd_ack_o         (rd_ack),
    .rd_comp_o        (rd_comp),
    .rd_err_o         (rd_err),
    .pop_o            (fifo_pop),
    .src_status_o     (src_status),
    .cnt_load_o       (cnt_load),
    .load_from_pend_o (load_from_pend),
    .cnt_dec_o        (cnt_dec),
    .pend_set_o       (pend_set),
    .pend_clr_o       (pend_clr),
    .take_idle_o      (take_idle),
    .take_promote_o   (take_promote),
    .pen_fire_o       (pen_fire),
    .sgl_comp_o       (sgl_comp)
  );

endmodule

// File: rtl/burst_read_ctrl_chk.sv
module burst_read_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] req_kind,
  input logic       addr_ack,
  input logic       push_addr,
  input logic       rd_ack,
  input logic       rd_comp,
  input logic       rd_err,
  input logic       fifo_pop,
  input logic       src_status,
  input logic       take_idle,
  input logic       take_promote,
  input logic       pen_fire,
  input logic       sgl_comp
);

  // R2 / R8: a forwarded address is always an acknowledged one
  p_push_with_addr_ack_r2: assert property (@(posedge clk) disable iff (rst)
    push_addr |-> addr_ack)
    else $error("p_push_with_addr_ack_r2");

  // R8: a promotion never coincides with a fresh start from idle
  p_promote_not_idle_r8: assert property (@(posedge clk) disable iff (rst)
    take_promote |-> !take_idle)
    else $error("p_promote_not_idle_r8");

  // R3: the cycle after a line/burst address acknowledge carries no data
  p_wait_after_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (take_idle && (req_kind == 2'd1 || req_kind == 2'd2)) |=> (!rd_ack && !rd_comp))
    else $error("p_wait_after_addr_r3");

  // R4: single read acknowledges the cycle after completion
  p_single_ack_after_comp_r4: assert property (@(posedge clk) disable iff (rst)
    sgl_comp |=> (rd_ack && !rd_comp))
    else $error("p_single_ack_after_comp_r4");

  // R5: final beat directly follows the second-to-last
  p_final_after_pen_r5: assert property (@(posedge clk) disable iff (rst)
    pen_fire |=> (rd_ack && rd_comp))
    else $error("p_final_after_pen_r5");

  // R6: pops only with acknowledges, never for status data
  p_pop_with_ack_r6: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> rd_ack)
    else $error("p_pop_with_ack_r6");

  p_status_never_pops_r6: assert property (@(posedge clk) disable iff (rst)
    src_status |-> !fifo_pop)
    else $error("p_status_never_pops_r6");

  // R7: errors only reported on an acknowledged far-side beat
  p_err_with_ack_r7: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> (rd_ack && !src_status))
    else $error("p_err_with_ack_r7");

endmodule

bind burst_read_ctrl burst_read_ctrl_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_kind     (req_kind),
  .addr_ack     (addr_ack),
  .push_addr    (push_addr),
  .rd_ack       (rd_ack),
  .rd_comp      (rd_comp),
  .rd_err       (rd_err),
  .fifo_pop     (fifo_pop),
  .src_status   (src_status),
  .take_idle    (take_idle),
  .take_promote (take_promote),
  .pen_fire     (pen_fire),
  .sgl_comp     (sgl_comp)
);

// File: tb/tb_burst_read_ctrl.sv
module tb_burst_read_ctrl;

  localparam int BEAT_W = 5;
  localparam int NVEC   = 39;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_status = 1'b0, promote = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [BEAT_W-1:0] req_beats = '0;
  logic fifo_empty = 1'b1, fifo_almost_empty = 1'b1, fifo_err = 1'b0;
  logic addr_ack, push_addr, rd_ack, rd_comp, rd_err, fifo_pop, src_status;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  burst_read_ctrl #(.BEAT_W(BEAT_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_beats(req_beats), .req_status(req_status), .promote(promote),
    .fifo_empty(fifo_empty), .fifo_almost_empty(fifo_almost_empty), .fifo_err(fifo_err),
    .addr_ack(addr_ack), .push_addr(push_addr), .rd_ack(rd_ack), .rd_comp(rd_comp),
    .rd_err(rd_err), .fifo_pop(fifo_pop), .src_status(src_status)
  );

  // expected bits: {addr_ack, push_addr, rd_ack, rd_comp, rd_err, fifo_pop, src_status}
  typedef struct packed {
    logic [3:0]        rq;
    logic              rv;
    logic [1:0]        kind;
    logic [BEAT_W-1:0] beats;
    logic              st;
    logic              pr;
    logic              emp;
    logic              aemp;
    logic              err;
    logic [6:0]        exp;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{4'd2,  1'b1, 2'd0, 5'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7'b1100000}, // R2 single far
    '{4'd4,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7'b0000000}, // R4 waiting data
    '{4'd4,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7'b0001000}, // R4 complete
    '{4'd6,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7'b0010010}, // R6 ack+pop
    '{4'd6,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7'b0000000}, // R6 idle no pop
    '{4'd2,  1'b1, 2'd0, 5'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7'b1100000}, // R2
    '{4'd4,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 7'b0001000}, // R4
    '{4'd7,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 7'b0010110}, // R7 error beat
    '{4'd2,  1'b1, 2'd0, 5'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 7'b1000000}, // R2 status: no push
    '{4'd10, 1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7'b0001001}, // R10
    '{4'd7,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 7'b0010001}, // R7 status: no err
    '{4'd2,  1'b1, 2'd1, 5'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'b1100000}, // R2 line x4
    '{4'd3,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'b0000000}, // R3 wait cycle
    '{4'd5,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7'b0010010}, // R5 beat1
    '{4'd5,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7'b0000000}, // R5 stall
    '{4'd5,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7'b0010010}, // R5 beat2
    '{4'd5,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7'b0000000}, // R5 need two queued
    '{4'd5,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'b0010010}, // R5 beat3
    '{4'd5,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7'b0011010}, // R5 final + comp
    '{4'd2,  1'b1, 2'd2, 5'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7'b1100000}, // R2 burst x2
    '{4'd8,  1'b0, 2'd1, 5'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 7'b1100000}, // R8 promote taken
    '{4'd9,  1'b0, 2'd2, 5'd7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 7'b0010010}, // R9 slot full
    '{4'd5,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7'b0011010}, // R5 burst final
    '{4'd8,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'b0010010}, // R8 no wait
    '{4'd9,  1'b0, 2'd0, 5'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 7'b0011010}, // R9 ack state
    '{4'd9,  1'b0, 2'd0, 5'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 7'b0000000}, // R9 idle
    '{4'd2,  1'b1, 2'd1, 5'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7'b1100000}, // R2 line x1
    '{4'd3,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7'b0000000}, // R3
    '{4'd5,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7'b0000000}, // R5 no data
    '{4'd5,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7'b0000000}, // R5 to final
    '{4'd7,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 7'b0011110}, // R7 final err
    '{4'd2,  1'b1, 2'd2, 5'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 7'b1000000}, // R2 status burst
    '{4'd10, 1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7'b0000001}, // R10 wait
    '{4'd6,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7'b0010001}, // R6 no pop
    '{4'd5,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7'b0010001}, // R5
    '{4'd5,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7'b0011001}, // R5
    '{4'd2,  1'b1, 2'd3, 5'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7'b1100000}, // R2 kind 3
    '{4'd4,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7'b0001000}, // R4
    '{4'd4,  1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 7'b0010010}  // R4
  };

  function automatic logic [6:0] outs();
    return {addr_ack, push_addr, rd_ack, rd_comp, rd_err, fifo_pop, src_status};
  endfunction

  task automatic check(input int rq, input int idx, input logic [6:0] exp);
    n_chk++;
    if (outs() !== exp) begin
      n_bad++;
      $display("FAIL R%0d step %0d: got %b expected %b", rq, idx, outs(), exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_valid = v.rv; req_kind = v.kind; req_beats = v.beats; req_status = v.st;
    promote = v.pr; fifo_empty = v.emp; fifo_almost_empty = v.aemp; fifo_err = v.err;
  endtask

  task automatic step(input vec_t v, input int idx);
    @(negedge clk);
    drive(v);
    #5 check(int'(v.rq), idx, v.exp);
  endtask

  initial begin
    vec_t q;
    q = '{4'd1, 1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7'b0000000};
    drive(q);
    repeat (3) @(negedge clk);
    #5 check(1, 0, 7'b0000000); // R1 reset state
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NVEC; i++) step(VEC[i], i);

    // R1: reset in the middle of a burst with a pending promotion
    step('{4'd1, 1'b1, 2'd2, 5'd4, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7'b1100000}, 100);
    step('{4'd1, 1'b0, 2'd1, 5'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 7'b1100000}, 101);
    @(negedge clk);
    drive('{4'd1, 1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'b0});
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #5 check(1, 102, 7'b0000000); // R1 idle after reset
    step('{4'd1, 1'b1, 2'd0, 5'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 7'b1000000}, 103);
    step('{4'd1, 1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'b0001001}, 104);
    step('{4'd1, 1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'b0010001}, 105);
    step('{4'd1, 1'b0, 2'd0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'b0000000}, 106); // R1 pending gone

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired: got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule